// File: doc/BRIEF.md
# Per-Load Stride Prefetch Table

This block watches the stream of executing loads and learns, separately for each load instruction, whether that load walks through memory with a fixed step. A table is selected by the low bits of the load's instruction address. Each entry holds the last 12-bit page offset the load touched, the last step between two of its accesses, a two-bit confidence state and the cache-line bits of the last address it prefetched. Every valid load reads its entry, computes the new step, writes the entry back in the same cycle and, once the step is confirmed, issues a prefetch request for the offset one step ahead.

The table has no tags. Two loads whose instruction addresses agree in the index bits share one entry and disturb each other's training. The request leaves on a registered valid/address pair one clock after the load that caused it. The cache, the address translation and any queue for the requests lie outside the block.

Top module: `stride_pf_table`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pf_valid` is 0. Reset empties every entry (state 00), so the first load after reset to any index gives no request.
- R2: The entry is chosen by `ld_ip` alone, with no tag. Loads that present the same `ld_ip` value continue one shared training history.
- R3: A load that finds its entry in state 00 (empty) records its offset, clears the step, moves the entry to state 01 (seen once) and gives no request.
- R4: A load that finds state 01 stores the step (its offset minus the stored offset, kept as a sign bit plus a 12-bit magnitude), moves to state 10 (step seen once) and gives no request.
- R5: A load that finds state 10 or 11 and whose step equals the stored step moves the entry to state 11 (steady). It issues a request whose address is its own offset plus the step. `pf_valid` and `pf_addr` show the request in the cycle after the load is presented.
- R6: A load that finds state 10 or 11 with a different step stores the new step, drops to state 01 and gives no request. Two further loads are needed before a request can appear again.
- R7: Negative steps are learned and predicted in the same way as positive ones.
- R8: A predicted address below 0 or above 4095 (outside the 4 KB page of the offset) gives no request. The entry still becomes steady, and its recorded prefetch line is left unchanged.
- R9: A load that finds state 11 gives no request when the predicted address falls in the same 64-byte line (offset bits 11:6) as the last request issued from that entry. The first request on entering state 11 from state 10 is never suppressed this way.
- R10: A cycle with `ld_valid` low leaves the table unchanged and gives no request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | An executing load is presented this cycle |
| ld_ip | input | IDX_W (8) | Low instruction-address bits of the load, used as the table index |
| ld_addr | input | 12 | Untranslated page offset of the load's address |
| pf_valid | output | 1 | Prefetch request valid, one cycle after its load |
| pf_addr | output | 12 | Predicted page offset of the request |

## Verification
The bench aims at training order. A design that predicts after only two accesses, or that keeps its confidence across a changed step, issues requests in the wrong cycles. Negative steps are driven to catch a design that treats the magnitude as unsigned. Steps that run off either end of the page are driven to catch a design that wraps the offset into a bogus request. Small steps inside one line are driven to catch a design whose duplicate filter misses repeats or swallows the first steady request. Idle cycles between loads, and two different load streams on one shared index, show whether an update leaks in without a load and whether the untagged entry is really shared.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int OFS_W    = 12;
    localparam int LPF_W    = 6;
    localparam int LINE_LSB = OFS_W - LPF_W;
    localparam int DIFF_W   = OFS_W + 1;
    localparam int SUM_W    = OFS_W + 2;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_SEEN  = 2'b01,
        ST_ONCE  = 2'b10,
        ST_LOCK  = 2'b11
    } pf_state_e;

    typedef struct packed {
        logic             neg;
        logic [OFS_W-1:0] mag;
    } stride_t;

    typedef struct packed {
        logic [OFS_W-1:0] last_ofs;
        stride_t          stride;
        pf_state_e        state;
        logic [LPF_W-1:0] last_line;
    } hist_entry_t;

    localparam hist_entry_t ENTRY_RESET = '0;

    function automatic stride_t pack_stride(input logic signed [DIFF_W-1:0] d);
        stride_t                  s;
        logic signed [DIFF_W-1:0] nd;
        nd    = -d;
        s.neg = d[DIFF_W-1];
        s.mag = d[DIFF_W-1] ? nd[OFS_W-1:0] : d[OFS_W-1:0];
        return s;
    endfunction

    function automatic logic signed [DIFF_W-1:0] unpack_stride(input stride_t s);
        logic signed [DIFF_W-1:0] m;
        m = {1'b0, s.mag};
        return s.neg ? -m : m;
    endfunction

endpackage

// File: rtl/spf_hist_array.sv
module spf_hist_array
    import spf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output hist_entry_t       rd_entry,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  hist_entry_t       wr_entry
);
    localparam int DEPTH = 1 << IDX_W;

    hist_entry_t mem_q [DEPTH];

    assign rd_entry = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ENTRY_RESET;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_entry;
        end
    end

    // R3
    wr_never_empty_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_entry.state != ST_EMPTY);

endmodule

// File: rtl/spf_train.sv
module spf_train
    import spf_pkg::*;
(
    input  logic [OFS_W-1:0] ld_ofs,
    input  hist_entry_t      rd_entry,
    output hist_entry_t      wr_entry,
    output logic             issue,
    output logic [OFS_W-1:0] pred_ofs
);
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] old_step;
    logic signed [SUM_W-1:0]  sum;
    logic                     step_match;
    logic                     in_page;
    logic                     same_line;

    always_comb begin
        diff       = $signed({1'b0, ld_ofs}) - $signed({1'b0, rd_entry.last_ofs});
        old_step   = unpack_stride(rd_entry.stride);
        sum        = $signed({2'b00, ld_ofs}) + $signed({old_step[DIFF_W-1], old_step});
        step_match = (diff == old_step);
        in_page    = (sum[SUM_W-1:OFS_W] == '0);
        pred_ofs   = sum[OFS_W-1:0];
        same_line  = (rd_entry.state == ST_LOCK) &&
                     (pred_ofs[OFS_W-1:LINE_LSB] == rd_entry.last_line);

        wr_entry          = rd_entry;
        wr_entry.last_ofs = ld_ofs;
        issue             = 1'b0;

        unique case (rd_entry.state)
            ST_EMPTY: begin
                wr_entry.state     = ST_SEEN;
                wr_entry.stride    = '0;
                wr_entry.last_line = '0;
            end
            ST_SEEN: begin
                wr_entry.state  = ST_ONCE;
                wr_entry.stride = pack_stride(diff);
            end
            default: begin
                if (step_match) begin
                    wr_entry.state = ST_LOCK;
                    if (in_page && !same_line) begin
                        issue              = 1'b1;
                        wr_entry.last_line = pred_ofs[OFS_W-1:LINE_LSB];
                    end
                end else begin
                    wr_entry.state  = ST_SEEN;
                    wr_entry.stride = pack_stride(diff);
                end
            end
        endcase
    end

endmodule

// File: rtl/spf_req_reg.sv
module spf_req_reg
    import spf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [OFS_W-1:0] fire_ofs,
    output logic             pf_valid,
    output logic [OFS_W-1:0] pf_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) begin
                pf_addr <= fire_ofs;
            end
        end
    end

endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
    import spf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_ip,
    input  logic [11:0]      ld_addr,
    output logic             pf_valid,
    output logic [11:0]      pf_addr
);
    hist_entry_t      rd_entry;
    hist_entry_t      wr_entry;
    logic             issue;
    logic [OFS_W-1:0] pred_ofs;

    spf_hist_array #(.IDX_W(IDX_W)) array_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (ld_ip),
        .rd_entry (rd_entry),
        .wr_en    (ld_valid),
        .wr_idx   (ld_ip),
        .wr_entry (wr_entry)
    );

    spf_train train_i (
        .ld_ofs   (ld_addr),
        .rd_entry (rd_entry),
        .wr_entry (wr_entry),
        .issue    (issue),
        .pred_ofs (pred_ofs)
    );

    spf_req_reg req_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (ld_valid && issue),
        .fire_ofs (pred_ofs),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !pf_valid);

    // R10
    pf_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> $past(ld_valid));

    // R5
    pf_needs_training_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> ($past(rd_entry.state) == ST_ONCE || $past(rd_entry.state) == ST_LOCK));

    // R9
    pf_no_repeat_line_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && $past(pf_valid) && ($past(ld_ip) == $past(ld_ip, 2)))
        |-> (pf_addr[OFS_W-1:LINE_LSB] != $past(pf_addr[OFS_W-1:LINE_LSB])));

endmodule

// File: tb/stride_pf_table_tb.sv
module stride_pf_table_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [7:0]  ld_ip = '0;
    logic [11:0] ld_addr = '0;
    logic        pf_valid;
    logic [11:0] pf_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_st   [256];
    int m_last [256];
    int m_step [256];
    int m_line [256];

    always #2.5 clk = ~clk;

    stride_pf_table dut_i (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_ip    (ld_ip),
        .ld_addr  (ld_addr),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_st[i] = 0; m_last[i] = 0; m_step[i] = 0; m_line[i] = 0;
        end
    endtask

    // one clock: present (or not) a load, then compare after the next edge
    task automatic step(input bit v, input int ip, input int addr, input string req);
        bit exp_v;
        int exp_a;
        int d;
        int pred;
        exp_v = 0;
        exp_a = 0;
        ld_valid = v;
        ld_ip    = 8'(ip);
        ld_addr  = 12'(addr);
        if (v) begin
            d = addr - m_last[ip];
            case (m_st[ip])
                0: begin m_st[ip] = 1; m_step[ip] = 0; m_line[ip] = 0; end
                1: begin m_st[ip] = 2; m_step[ip] = d; end
                default: begin
                    if (d == m_step[ip]) begin
                        pred = addr + m_step[ip];
                        if (pred >= 0 && pred < 4096 &&
                            !(m_st[ip] == 3 && (pred / 64) == m_line[ip])) begin
                            exp_v = 1;
                            exp_a = pred;
                            m_line[ip] = pred / 64;
                        end
                        m_st[ip] = 3;
                    end else begin
                        m_st[ip] = 1;
                        m_step[ip] = d;
                    end
                end
            endcase
            m_last[ip] = addr;
        end
        @(negedge clk);
        total++;
        if (pf_valid !== exp_v || (exp_v && pf_addr !== 12'(exp_a))) begin
            bad++;
            $display("FAIL %s: ip=%0h addr=%0h got valid=%0b addr=%0h expected valid=%0b addr=%0h",
                     req, ip, addr, pf_valid, pf_addr, exp_v, exp_a);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        total++;
        if (pf_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: pf_valid during reset got %0b expected 0", pf_valid);
        end
        rst = 1'b0;
        step(0, 0, 0, "R1");
        // R1 R3 R4 R5: positive step of one line
        step(1, 'h10, 'h100, "R3");
        step(1, 'h10, 'h140, "R4");
        step(1, 'h10, 'h180, "R5");
        step(1, 'h10, 'h1C0, "R5");
        // R7: negative step
        step(1, 'h21, 'h800, "R7");
        step(1, 'h21, 'h7C0, "R7");
        step(1, 'h21, 'h780, "R7");
        step(1, 'h21, 'h740, "R7");
        // R9: step of 8 stays inside a line
        for (int k = 0; k < 10; k++) step(1, 'h33, k * 8, "R9");
        // R9: zero step, repeated address
        for (int k = 0; k < 4; k++) step(1, 'h34, 'h555, "R9");
        // R8: running off the top of the page
        step(1, 'h44, 'hE80, "R8");
        step(1, 'h44, 'hF00, "R8");
        step(1, 'h44, 'hF80, "R8");
        step(1, 'h44, 'h000, "R6");
        // R8: running off the bottom with a negative step
        step(1, 'h45, 'h0C0, "R8");
        step(1, 'h45, 'h080, "R8");
        step(1, 'h45, 'h040, "R8");
        step(1, 'h45, 'h000, "R8");
        // R6: break a steady stream, then retrain
        step(1, 'h10, 'h300, "R6");
        step(1, 'h10, 'h340, "R6");
        step(1, 'h10, 'h380, "R6");
        // R10: idle cycles with changing address and index
        step(0, 'h10, 'hABC, "R10");
        step(0, 'h10, 'h000, "R10");
        step(0, 'h21, 'hFFF, "R10");
        step(1, 'h10, 'h3C0, "R10");
        // R2: a second load on the same shared index continues the history
        step(1, 'h10, 'h400, "R2");
        step(1, 'h10, 'h900, "R2");
        step(1, 'h21, 'h700, "R2");
        // mixed interleaving of two indices
        for (int k = 0; k < 6; k++) begin
            step(1, 'h50, 'h200 + k * 'h100, "R5");
            step(1, 'h51, 'hA00 - k * 'h48, "R7");
        end
        // R1: reset in the middle wipes training
        rst = 1'b1;
        model_reset();
        step(0, 0, 0, "R1");
        rst = 1'b0;
        step(1, 'h10, 'h440, "R1");
        step(1, 'h10, 'h480, "R1");
        step(1, 'h10, 'h4C0, "R1");
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule